// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Pin Set/Clear

This block is a 16-pin general-purpose I/O port that sits on a simple register bus. Software picks a mode for each pin (input, push-pull output or peripheral-driven), writes the output latch either as a whole or through a write-only set/clear register, and reads the synchronized pad levels through an input register. The set/clear register changes only the pins named in one bus write. Two pieces of software that update different pins of the same port therefore never need a read-modify-write sequence, and neither can undo the other's change.

Pins in peripheral mode take their level and their drive enable from a peripheral and ignore the output latch. Pins in output mode drive the latched value both high and low. Pins in input mode, and in the reserved mode code, do not drive the pad.

The read path is a two-state machine. `BUS_IDLE` is the rest state. The transition IDLE→RESP is taken on any read request. In `BUS_RESP` the port presents the captured read data with a valid flag. The transition RESP→RESP is taken when another read request arrives in that cycle, and RESP→IDLE is taken when none does. Writes take effect at the clock edge where they are presented, in either state.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch is 0, every pin is in input mode (mode register 0), no pad is driven, and `bus_rvalid` is 0 with `bus_rdata` 0.
- R2: A read request sampled at a clock edge raises `bus_rvalid` for exactly the following cycle, with `bus_rdata` holding the addressed register. In every other cycle `bus_rvalid` is 0 and `bus_rdata` is 0.
- R3: A write to offset 0x14 replaces all 16 output latch bits with `bus_wdata[15:0]`. A read of 0x14 returns the latch in bits 15:0 and zeros above.
- R4: A write to offset 0x18 sets every latch bit whose bit in `bus_wdata[15:0]` is 1 and clears every latch bit whose bit in `bus_wdata[31:16]` is 1. All other latch bits keep their value.
- R5: When a 0x18 write has both the set bit (bit i) and the clear bit (bit 16+i) at 1 for a pin, that pin's latch bit becomes 1.
- R6: A read of offset 0x18 returns 0 and leaves the output latch unchanged.
- R7: Offset 0x00 is the mode register, read/write, 2 bits per pin with pin i at bits 2i+1:2i. The codes are 00 input, 01 push-pull output, 10 peripheral, and 11 reserved (behaves as input).
- R8: A pin in output mode has `pad_oe` 1 and `pad_out` equal to its latch bit.
- R9: A pin in peripheral mode has `pad_out` equal to `alt_out` and `pad_oe` equal to `alt_oe` for that pin, whatever its latch bit.
- R10: A pin in input or reserved mode has `pad_oe` 0, and `pad_out` carries its latch bit.
- R11: Offset 0x10 returns the pad levels in bits 15:0 and zeros above, through a two-flop synchronizer. A pad change set up before edge k is returned by a read request sampled at edge k+2 and not by one sampled at edge k+1. Writes to 0x10 change nothing.
- R12: Reads of any other offset return 0. Writes to them change neither the latch nor the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pad_in | input | 16 | Pad levels as seen on the pins |
| pad_out | output | 16 | Level driven to each pad |
| pad_oe | output | 16 | Drive enable for each pad |
| alt_out | input | 16 | Peripheral level for pins in peripheral mode |
| alt_oe | input | 16 | Peripheral drive enable for pins in peripheral mode |

## Verification
A corrupted output latch shows on `pad_out` of every output-mode pin in the same cycle, and on the next read of 0x14 one cycle after the request. A wrong mode entry shows at once as a wrong `pad_oe` or as a pad following the wrong source. A misplaced synchronizer stage shifts when a pad change first shows up in 0x10, so the bench reads back-to-back around that edge to catch a change that appears one cycle early or late. A read-state machine stuck in RESP shows as `bus_rvalid` held high in the idle cycle after a single read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_IN     = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_OUT    = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SETCLR = 8'h18;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_OUTPUT = 2'b01,
        PM_ALT    = 2'b10,
        PM_RSVD   = 2'b11
    } pin_mode_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] idr_q
);
    logic [NPINS-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            idr_q  <= '0;
        end else begin
            meta_q <= pad_in;
            idr_q  <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
    parameter int NPINS  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odr_we,
    input  logic              srs_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [NPINS-1:0]  odr_q
);
    localparam int CLR_LSB = DATA_W / 2;

    logic [NPINS-1:0] set_m, clr_m, base_d, odr_d;

    assign set_m = srs_we ? wdata[NPINS-1:0]       : '0;
    assign clr_m = srs_we ? wdata[CLR_LSB +: NPINS] : '0;

    // A whole-latch write lands first, set/clear is layered on top;
    // the OR after the AND-clear gives set priority.
    always_comb begin
        base_d = odr_we ? wdata[NPINS-1:0] : odr_q;
        odr_d  = (base_d & ~clr_m) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) odr_q <= '0;
        else        odr_q <= odr_d;
    end

    // R5: every requested set bit reads 1 afterwards
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (srs_we && !odr_we) |=> ((odr_q & $past(set_m)) == $past(set_m)));
    // R4: clears without a matching set end at 0
    a_r4_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (srs_we && !odr_we) |=> ((odr_q & $past(clr_m & ~set_m)) == '0));
    // R4: unnamed bits untouched
    a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (srs_we && !odr_we) |=>
            (((odr_q ^ $past(odr_q)) & ~$past(set_m | clr_m)) == '0));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!srs_we && !odr_we) |=> $stable(odr_q));
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_we,
    input  logic [2*NPINS-1:0] mode_wdata,
    input  logic [NPINS-1:0]   odr_q,
    input  logic [NPINS-1:0]   alt_out,
    input  logic [NPINS-1:0]   alt_oe,
    output logic [2*NPINS-1:0] mode_q,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e pm;
        assign pm = pin_mode_e'(mode_q[2*i +: 2]);

        always_comb begin
            unique case (pm)
                PM_OUTPUT: begin
                    pad_out[i] = odr_q[i];
                    pad_oe[i]  = 1'b1;
                end
                PM_ALT: begin
                    pad_out[i] = alt_out[i];
                    pad_oe[i]  = alt_oe[i];
                end
                PM_INPUT, PM_RSVD: begin
                    pad_out[i] = odr_q[i];
                    pad_oe[i]  = 1'b0;
                end
                default: begin
                    pad_out[i] = odr_q[i];
                    pad_oe[i]  = 1'b0;
                end
            endcase
        end

        // R8: output pins drive the latch
        a_r8_output_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b01) |-> (pad_oe[i] && pad_out[i] == odr_q[i]));
        // R9: peripheral pins follow the peripheral
        a_r9_alt_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b10) |->
                (pad_oe[i] == alt_oe[i] && pad_out[i] == alt_out[i]));
        // R10: input and reserved pins float
        a_r10_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i] == mode_q[2*i+1]) |-> !pad_oe[i]);
    end
endmodule

// File: rtl/gpio_bus_if.sv
module gpio_bus_if
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [2*NPINS-1:0] mode_q,
    input  logic [NPINS-1:0]   odr_q,
    input  logic [NPINS-1:0]   idr_q,
    output logic               mode_we,
    output logic               odr_we,
    output logic               srs_we,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid
);
    localparam int MODE_W = 2 * NPINS;

    bus_state_e state_q, state_d;
    logic [DATA_W-1:0] rd_mux;

    assign mode_we = bus_we && (bus_addr == OFF_MODE);
    assign odr_we  = bus_we && (bus_addr == OFF_OUT);
    assign srs_we  = bus_we && (bus_addr == OFF_SETCLR);

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_MODE)     rd_mux[MODE_W-1:0] = mode_q;
        else if (bus_addr == OFF_IN)  rd_mux[NPINS-1:0]  = idr_q;
        else if (bus_addr == OFF_OUT) rd_mux[NPINS-1:0]  = odr_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_re) state_d = BUS_RESP;
            BUS_RESP: state_d = bus_re ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= bus_re ? rd_mux : '0;
            bus_rvalid <= (state_d == BUS_RESP);
        end
    end

    // R2: valid exactly one cycle after each request
    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> bus_rvalid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (!bus_rvalid && bus_rdata == '0));
    // R6: set/clear register reads as zero
    a_r6_setclr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == OFF_SETCLR) |=> (bus_rdata == '0));
    a_r2_state_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid == (state_q == BUS_RESP));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe
);
    localparam int MODE_W = 2 * NPINS;

    logic               mode_we, odr_we, srs_we;
    logic [MODE_W-1:0]  mode_q;
    logic [NPINS-1:0]   odr_q, idr_q;

    gpio_bus_if #(.NPINS(NPINS)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .mode_q(mode_q), .odr_q(odr_q), .idr_q(idr_q),
        .mode_we(mode_we), .odr_we(odr_we), .srs_we(srs_we),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    gpio_out_reg #(.NPINS(NPINS), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .odr_we(odr_we), .srs_we(srs_we), .wdata(bus_wdata),
        .odr_q(odr_q)
    );

    gpio_pin_ctrl #(.NPINS(NPINS)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_wdata(bus_wdata[MODE_W-1:0]),
        .odr_q(odr_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .mode_q(mode_q), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .idr_q(idr_q)
    );

    // R12: one decoded write strobe at most
    a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_we, odr_we, srs_we}));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] pad_in = '0, pad_out, pad_oe;
    logic [15:0] alt_out = '0, alt_oe = '0;

    int checks = 0, fails = 0;
    logic [15:0] m_odr = '0;
    logic [31:0] m_mode = '0;
    logic [31:0] rd;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] setclr(input logic [15:0] o, input logic [31:0] w);
        return (o & ~w[31:16]) | w[15:0];
    endfunction

    function automatic logic [15:0] exp_oe(input logic [31:0] m, input logic [15:0] aoe);
        logic [15:0] r;
        for (int i = 0; i < 16; i++)
            r[i] = (m[2*i +: 2] == 2'b01) ? 1'b1 : (m[2*i +: 2] == 2'b10) ? aoe[i] : 1'b0;
        return r;
    endfunction

    function automatic logic [15:0] exp_out(input logic [31:0] m, input logic [15:0] o,
                                            input logic [15:0] ao);
        logic [15:0] r;
        for (int i = 0; i < 16; i++)
            r[i] = (m[2*i +: 2] == 2'b10) ? ao[i] : o[i];
        return r;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
        case (a)
            8'h00: m_mode = d;
            8'h14: m_odr = d[15:0];
            8'h18: m_odr = setclr(m_odr, d);
            default: ;
        endcase
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
        check("R2 rvalid", {31'b0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic check_pads(input string tag);
        check({tag, " pad_oe"}, {16'b0, pad_oe}, {16'b0, exp_oe(m_mode, alt_oe)});
        check({tag, " pad_out"}, {16'b0, pad_out}, {16'b0, exp_out(m_mode, m_odr, alt_out)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", {16'b0, pad_oe}, 32'd0);
        check("R1 rvalid", {31'b0, bus_rvalid}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rdreg(8'h14, rd); check("R1 latch", rd, 32'd0);
        rdreg(8'h00, rd); check("R1 mode", rd, 32'd0);
        @(negedge clk);
        check("R2 idle rvalid", {31'b0, bus_rvalid}, 32'd0);
        check("R2 idle rdata", bus_rdata, 32'd0);

        // R3 whole write
        wr(8'h14, 32'hABCD_1234);
        rdreg(8'h14, rd); check("R3 latch", rd, 32'h0000_1234);
        // R4 set/clear
        wr(8'h18, 32'h00F0_0F00);
        rdreg(8'h14, rd); check("R4 setclr", rd, {16'b0, m_odr});
        check("R4 value", {16'b0, m_odr}, 32'h0000_1F04);
        // R5 set wins
        wr(8'h18, 32'h0001_0000);
        wr(8'h18, 32'h8001_8001);
        rdreg(8'h14, rd); check("R5 set wins", rd, {16'b0, m_odr | 16'h8001});
        // R6 read of set/clear
        rdreg(8'h18, rd); check("R6 reads zero", rd, 32'd0);
        rdreg(8'h14, rd); check("R6 latch kept", rd, {16'b0, m_odr});

        // R7..R10 modes: pins cycle input, output, alt, reserved
        wr(8'h00, 32'hE4E4_E4E4);
        rdreg(8'h00, rd); check("R7 mode readback", rd, 32'hE4E4_E4E4);
        alt_out = 16'h5A5A; alt_oe = 16'hFFFF; #1;
        check_pads("R8 R9 R10 mixed");
        alt_out = 16'hA5A5; alt_oe = 16'h0F0F; #1;
        check_pads("R9 alt change");
        wr(8'h14, 32'h0000_FFFF);
        check_pads("R8 latch change");
        check("R9 alt ignores latch", {16'b0, pad_out & 16'h4444}, {16'b0, alt_out & 16'h4444});
        check("R10 no drive", {16'b0, pad_oe & 16'h9999}, 32'd0);

        // R11 synchronizer timing
        pad_in = 16'h0000;
        repeat (3) @(negedge clk);
        pad_in = 16'hC3A5;
        rdreg(8'h10, rd); check("R11 edge k old", rd, 32'd0);
        rdreg(8'h10, rd); check("R11 edge k+1 old", rd, 32'd0);
        rdreg(8'h10, rd); check("R11 edge k+2 new", rd, 32'h0000_C3A5);
        wr(8'h10, 32'hFFFF_FFFF);
        rdreg(8'h10, rd); check("R11 write ignored", rd, 32'h0000_C3A5);

        // R12 unmapped
        rdreg(8'h04, rd); check("R12 read 04", rd, 32'd0);
        rdreg(8'h1C, rd); check("R12 read 1C", rd, 32'd0);
        wr(8'h1C, 32'h0000_0000);
        wr(8'h04, 32'hFFFF_FFFF);
        rdreg(8'h14, rd); check("R12 latch kept", rd, {16'b0, m_odr});
        rdreg(8'h00, rd); check("R12 mode kept", rd, m_mode);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] d;
            op = $urandom_range(0, 5);
            d = $urandom();
            alt_out = 16'($urandom()); alt_oe = 16'($urandom());
            case (op)
                0: wr(8'h14, d);
                1, 2: wr(8'h18, d);
                3: wr(8'h00, d);
                4: begin rdreg(8'h14, rd); check("R4 random latch", rd, {16'b0, m_odr}); end
                default: begin rdreg(8'h00, rd); check("R7 random mode", rd, m_mode); end
            endcase
            #1;
            check_pads("R8 R9 R10 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule